// File: doc/BRIEF.md
# Flash Chip Erase Sequencer

This controller sits on the host side of a parallel 8-bit flash device. It drives the device's address lines, its data lines and its active-low chip-enable, output-enable and write-enable strobes. A single-cycle `start` pulse makes it erase the whole array and then prove that the erase worked. The command to erase is sent as the byte 20h in two back-to-back write cycles. The controller then holds the erase pulse open for a timed interval. It closes that pulse with an erase-verify write of A0h that carries the byte address to check. After a short recovery wait it reads that address back.

An erased byte reads FFh, and when it does the controller moves to the next address. When a byte reads any other value, the controller sends another doubled 20h erase and continues verifying from that same address, not from zero. When the number of erase pulses reaches a parameterised limit while a byte is still not erased, the controller raises `fail` and reports the address that failed. It then writes FFh twice, which aborts the erase and returns the device to read mode. The erase pulse width and the recovery wait are given in microseconds and turned into clock cycles with a `CLK_HZ` parameter, so a simulation can run with short values.

Top module: `fes_chip_erase`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low. All three strobes (`flash_ce_n`, `flash_oe_n`, `flash_we_n`) are high and `flash_dq_oe` is low. Whenever `busy` is low, `flash_ce_n` stays high.
- R2: A `start` pulse while idle raises `busy` on the next clock edge. `start` while busy has no effect on the bus sequence or on the result. `busy` falls only in the cycle where `done` pulses.
- R3: Each erase pulse is opened by two consecutive write cycles carrying 20h, with no other write between them. A single 20h is never followed by a write of another value.
- R4: An erase pulse lasts from the rising write-enable edge of the second 20h write to the rising write-enable edge of the next write. It is at least ERASE_US microseconds long, that is at least ERASE_US*CLK_HZ/10^6 cycles.
- R5: Each verify step is a write of A0h with the address to check on `flash_addr`. After the recovery wait it is followed by exactly one read cycle at that same address, before any further write.
- R6: After the first erase pulse, the erase-verify addresses run upward from 0 to 2^ADDR_W-1. Each address is verified until it reads FFh.
- R7: If a read returns anything other than FFh, the next write is a new doubled 20h erase. The verify that follows uses the same address.
- R8: When the last address reads FFh, `done` pulses for one cycle with `fail` low and `busy` falls in that cycle. No FFh write is issued on success.
- R9: If a byte is still not FFh after MAX_PULSES erase pulses, the controller writes FFh twice. `done` then pulses with `fail` high. `fail` stays high and `fail_addr` holds that byte's address until the next start.
- R10: Write-enable and output-enable are never low together. Chip-enable is low whenever either of them is low. `flash_dq_oe` is low whenever output-enable is low.
- R11: A single operation issues at most MAX_PULSES erase pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to erase and verify |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse when an operation ends |
| fail | output | 1 | High after an operation that hit the pulse limit |
| fail_addr | output | ADDR_W | Address of the byte that did not erase |
| flash_addr | output | ADDR_W | Flash address lines |
| flash_dq_out | output | 8 | Byte driven onto the flash data lines |
| flash_dq_oe | output | 1 | High while the controller drives the data lines |
| flash_dq_in | input | 8 | Byte read from the flash data lines |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
The assertions assume that reset is applied before the first start. They read the command byte from `flash_dq_out` at each rising write-enable edge, which relies on the controller holding the data stable through the hold phase. The pulse-limit check also assumes that `start` arriving while the controller is busy is ignored. The bench keeps to these assumptions: it releases reset before any stimulus, and it drives `start` only on falling clock edges. The flash model it uses erases each byte only after a chosen number of pulses. Those per-byte counts are drawn at random but capped at MAX_PULSES, except in the one directed case that forces the limit.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int DQ_W = 8;

  localparam logic [DQ_W-1:0] CMD_ERASE  = 8'h20;
  localparam logic [DQ_W-1:0] CMD_VERIFY = 8'hA0;
  localparam logic [DQ_W-1:0] CMD_ABORT  = 8'hFF;
  localparam logic [DQ_W-1:0] BLANK_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_ERA1, SQ_ERA2, SQ_PULSE, SQ_VFY,
    SQ_RECOV, SQ_READ, SQ_ABT1, SQ_ABT2
  } seq_state_t;

  typedef enum logic [1:0] {
    BP_IDLE, BP_SETUP, BP_STROBE, BP_HOLD
  } bus_phase_t;
endpackage

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/fes_bus_cycle.sv
module fes_bus_cycle
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [DQ_W-1:0]   rdata,
  output logic              fin
);
  localparam int SC_W = $clog2(STROBE_CYC + 1);

  bus_phase_t        phase;
  logic [SC_W-1:0]   scnt;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= BP_IDLE;
      scnt   <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdata  <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (phase)
        BP_IDLE: if (go) begin
          wr_q   <= wr;
          addr_q <= addr_i;
          wdat_q <= wdata_i;
          phase  <= BP_SETUP;
        end
        BP_SETUP: begin
          scnt  <= SC_W'(STROBE_CYC - 1);
          phase <= BP_STROBE;
        end
        BP_STROBE: begin
          if (scnt == '0) begin
            if (!wr_q) rdata <= dq_in;
            phase <= BP_HOLD;
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        default: begin
          phase <= BP_IDLE;
          fin   <= 1'b1;
        end
      endcase
    end
  end

  assign ce_n   = (phase == BP_IDLE);
  assign we_n   = !((phase == BP_STROBE) && wr_q);
  assign oe_n   = !((phase == BP_STROBE) && !wr_q);
  assign dq_oe  = wr_q && (phase != BP_IDLE);
  assign addr_o = addr_q;
  assign dq_out = wdat_q;
endmodule

// File: rtl/fes_chip_erase.sv
module fes_chip_erase
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CLK_HZ     = 50_000_000,
  parameter int ERASE_US   = 10_000,
  parameter int RECOV_US   = 6,
  parameter int STROBE_CYC = 3,
  parameter int MAX_PULSES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [7:0]        flash_dq_in,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n
);
  localparam int CYC_PER_US = (CLK_HZ + 999_999) / 1_000_000;
  localparam int ERASE_CYC  = (CYC_PER_US * ERASE_US < 1) ? 1 : CYC_PER_US * ERASE_US;
  localparam int RECOV_CYC  = (CYC_PER_US * RECOV_US < 1) ? 1 : CYC_PER_US * RECOV_US;
  localparam int TMR_MAX    = (ERASE_CYC > RECOV_CYC) ? ERASE_CYC : RECOV_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int PC_W       = $clog2(MAX_PULSES + 1);

  seq_state_t        state;
  logic              pend;
  logic [ADDR_W-1:0] cur_addr;
  logic [PC_W-1:0]   pulses;

  logic              bus_go, bus_wr, bus_fin;
  logic [ADDR_W-1:0] bus_addr;
  logic [DQ_W-1:0]   bus_wdata, bus_rdata;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              cmd_state;

  always_comb begin
    cmd_state = 1'b1;
    bus_wr    = 1'b1;
    bus_wdata = CMD_ERASE;
    bus_addr  = '0;
    case (state)
      SQ_ERA1, SQ_ERA2: bus_wdata = CMD_ERASE;
      SQ_VFY: begin
        bus_wdata = CMD_VERIFY;
        bus_addr  = cur_addr;
      end
      SQ_READ: begin
        bus_wr   = 1'b0;
        bus_addr = cur_addr;
      end
      SQ_ABT1, SQ_ABT2: bus_wdata = CMD_ABORT;
      default: cmd_state = 1'b0;
    endcase
  end

  assign bus_go   = cmd_state && !pend;
  assign tmr_load = bus_fin && ((state == SQ_ERA2) || (state == SQ_VFY));
  assign tmr_val  = (state == SQ_ERA2) ? TMR_W'(ERASE_CYC) : TMR_W'(RECOV_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      pend      <= 1'b0;
      cur_addr  <= '0;
      pulses    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      if (bus_go) pend <= 1'b1;
      case (state)
        SQ_IDLE: if (start) begin
          busy     <= 1'b1;
          fail     <= 1'b0;
          cur_addr <= '0;
          pulses   <= '0;
          state    <= SQ_ERA1;
        end
        SQ_PULSE: if (tmr_exp) state <= SQ_VFY;
        SQ_RECOV: if (tmr_exp) state <= SQ_READ;
        default: if (bus_fin) begin
          pend <= 1'b0;
          case (state)
            SQ_ERA1: state <= SQ_ERA2;
            SQ_ERA2: begin
              pulses <= pulses + 1'b1;
              state  <= SQ_PULSE;
            end
            SQ_VFY:  state <= SQ_RECOV;
            SQ_READ: begin
              if (bus_rdata == BLANK_BYTE) begin
                if (cur_addr == {ADDR_W{1'b1}}) begin
                  busy  <= 1'b0;
                  done  <= 1'b1;
                  state <= SQ_IDLE;
                end else begin
                  cur_addr <= cur_addr + 1'b1;
                  state    <= SQ_VFY;
                end
              end else if (pulses == PC_W'(MAX_PULSES)) begin
                fail_addr <= cur_addr;
                state     <= SQ_ABT1;
              end else begin
                state <= SQ_ERA1;
              end
            end
            SQ_ABT1: state <= SQ_ABT2;
            default: begin
              busy  <= 1'b0;
              done  <= 1'b1;
              fail  <= 1'b1;
              state <= SQ_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  fes_wait_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  fes_bus_cycle #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(bus_go), .wr(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .dq_in(flash_dq_in), .ce_n(flash_ce_n), .oe_n(flash_oe_n),
    .we_n(flash_we_n), .addr_o(flash_addr), .dq_out(flash_dq_out), .dq_oe(flash_dq_oe),
    .rdata(bus_rdata), .fin(bus_fin)
  );
endmodule

// File: rtl/fes_chip_erase_chk.sv
module fes_chip_erase_chk #(
  parameter int MIN_PULSE  = 4,
  parameter int MAX_PULSES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       dq_oe,
  input logic [7:0] dq_out
);
  localparam int WC_W = $clog2(MIN_PULSE + 1) + 1;
  localparam int PC_W = $clog2(MAX_PULSES + 2);

  logic            we_q, in_pulse;
  logic [7:0]      last_b;
  logic [WC_W-1:0] wcnt;
  logic [PC_W-1:0] pcnt;
  logic            we_rise;

  assign we_rise = we_n && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      in_pulse <= 1'b0;
      last_b   <= '0;
      wcnt     <= '0;
      pcnt     <= '0;
    end else begin
      we_q <= we_n;
      if (start && !busy) pcnt <= '0;
      if (we_rise) begin
        last_b <= dq_out;
        wcnt   <= '0;
        if (in_pulse) in_pulse <= 1'b0;
        else if (dq_out == 8'h20 && last_b == 8'h20) begin
          in_pulse <= 1'b1;
          if (!(start && !busy)) pcnt <= pcnt + 1'b1;
        end
      end else if (wcnt < WC_W'(MIN_PULSE)) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n));
  // R10
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !oe_n) |-> !ce_n);
  // R10
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !dq_oe);
  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && in_pulse) |-> (wcnt >= WC_W'(MIN_PULSE)));
  // R11
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) pcnt <= PC_W'(MAX_PULSES));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R9
  fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail) |-> done);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ce_n);
endmodule

bind fes_chip_erase fes_chip_erase_chk #(.MIN_PULSE(ERASE_CYC), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .ce_n(flash_ce_n), .oe_n(flash_oe_n), .we_n(flash_we_n), .dq_oe(flash_dq_oe),
  .dq_out(flash_dq_out)
);

// File: tb/sim_fes_chip_erase.sv
module sim_fes_chip_erase;
  localparam int CLK_PERIOD = 10;
  localparam int AW        = 4;
  localparam int N         = 1 << AW;
  localparam int MAXP      = 4;
  localparam int ERASE_CYC = 20;
  localparam int LIST      = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, fail, dq_oe, ce_n, oe_n, we_n;
  logic [AW-1:0] fail_addr, faddr;
  logic [7:0] dq_out, dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  fes_chip_erase #(.ADDR_W(AW), .CLK_HZ(1_000_000), .ERASE_US(ERASE_CYC), .RECOV_US(2),
                   .STROBE_CYC(2), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .flash_addr(faddr), .flash_dq_out(dq_out), .flash_dq_oe(dq_oe),
    .flash_dq_in(dq_in), .flash_ce_n(ce_n), .flash_oe_n(oe_n), .flash_we_n(we_n)
  );

  int need [N];
  int exp_a0 [LIST];
  int exp_len, exp_pulses, exp_faddr;
  bit exp_fail;
  int checks = 0, errors = 0;

  // flash model state, single writer: the negedge process below
  bit model_clr = 1'b0;
  bit we_prev, oe_prev, in_pulse, half20, armed;
  int pulses_seen, wcnt, ff_n, a0_n, order_err, seq_err, width_err, rd_err;
  logic [7:0] last_b;
  logic [AW-1:0] lat;

  assign dq_in = (pulses_seen >= need[faddr]) ? 8'hFF : (8'h3C ^ {4'h0, faddr});

  always @(negedge clk) begin
    if (model_clr) begin
      we_prev = 1'b1; oe_prev = 1'b1; in_pulse = 0; half20 = 0; armed = 0;
      pulses_seen = 0; wcnt = 0; ff_n = 0; a0_n = 0; order_err = 0;
      seq_err = 0; width_err = 0; rd_err = 0; last_b = 8'h00; lat = '0;
    end else begin
      if (in_pulse) wcnt++;
      if (we_n && !we_prev) begin
        if (in_pulse) begin
          if (wcnt < ERASE_CYC) width_err++;
          in_pulse = 0;
        end else if (dq_out == 8'h20 && last_b == 8'h20) begin
          in_pulse = 1; wcnt = 0; pulses_seen++;
        end
        if (half20 && dq_out != 8'h20) seq_err++;
        half20 = (dq_out == 8'h20 && last_b != 8'h20);
        if (dq_out == 8'hA0) begin
          lat = faddr; armed = 1;
          if (a0_n >= exp_len || int'(faddr) != exp_a0[a0_n]) order_err++;
          a0_n++;
        end
        if (dq_out == 8'hFF) ff_n++;
        if (armed && dq_out != 8'hA0) rd_err++;
        last_b = dq_out;
      end
      if (!oe_n && oe_prev) begin
        if (!armed || faddr != lat) rd_err++;
        armed = 0;
      end
      we_prev = we_n; oe_prev = oe_n;
    end
  end

  function automatic void compute_expect();
    int p = 1, a = 0;
    exp_len = 0; exp_fail = 0; exp_faddr = 0;
    while (a < N) begin
      exp_a0[exp_len] = a; exp_len++;
      if (need[a] <= p) a++;
      else if (p == MAXP) begin exp_fail = 1; exp_faddr = a; break; end
      else p++;
    end
    exp_pulses = p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_case(input bit poke_start);
    int wd = 0, busy_gaps = 0;
    bit seen_done = 0, got_fail = 0;
    compute_expect();
    @(negedge clk); model_clr = 1;
    @(negedge clk); model_clr = 0;
    start = 1;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    while (!seen_done && wd < 20000) begin
      @(negedge clk);
      wd++;
      if (poke_start && wd == 60) start = 1;
      else start = 0;
      if (done) begin seen_done = 1; got_fail = fail; end
      else if (!busy) busy_gaps++;
    end
    start = 0;
    chk(seen_done, "R2 watchdog done", int'(seen_done), 1);
    chk(busy_gaps == 0, "R2 busy held", busy_gaps, 0);
    chk(busy === 1'b0, "R8 busy low at done", busy, 0);
    chk(got_fail == exp_fail, "R8 R9 fail flag", got_fail, exp_fail);
    if (exp_fail) begin
      chk(int'(fail_addr) == exp_faddr, "R9 fail_addr", fail_addr, exp_faddr);
      chk(ff_n == 2, "R9 abort writes", ff_n, 2);
    end else begin
      chk(ff_n == 0, "R8 no abort writes", ff_n, 0);
    end
    chk(pulses_seen == exp_pulses, "R11 pulse count", pulses_seen, exp_pulses);
    chk(a0_n == exp_len && order_err == 0, "R6 R7 verify order", order_err, 0);
    chk(seq_err == 0, "R3 doubled erase", seq_err, 0);
    chk(width_err == 0, "R4 pulse width", width_err, 0);
    chk(rd_err == 0, "R5 verify read", rd_err, 0);
    repeat (3) @(negedge clk);
    chk(ce_n === 1'b1 && fail === got_fail, "R1 R9 idle hold", ce_n, 1);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4242);
    for (int i = 0; i < N; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && fail === 0, "R1 reset status", busy, 0);
    chk(ce_n === 1 && oe_n === 1 && we_n === 1 && dq_oe === 0, "R1 reset strobes", ce_n, 1);
    rst_n = 1;
    // directed: all bytes erase on first pulse
    run_case(0);
    // directed R7: byte 5 needs a second pulse
    need[5] = 2;
    run_case(0);
    // directed: last byte needs three pulses, start poked while busy (R2)
    need[5] = 1; need[N-1] = 3;
    run_case(1);
    // random per-byte needs within the limit
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++)
        need[i] = 1 + ((($urandom + seed) % 6 == 0) ? int'($urandom % MAXP) : 0);
      run_case(0);
    end
    // directed R9: byte 7 never erases
    for (int i = 0; i < N; i++) need[i] = 1;
    need[2] = 2; need[7] = 99;
    run_case(0);
    // recovery after failure
    need[7] = 1;
    run_case(0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule